// File: doc/BRIEF.md
# Quadrature Encoder Fractional Phase Accumulator

This block turns a rotary quadrature encoder into a fine phase adjustment for a delayed waveform. It decodes the two encoder phases into clicks. Each click adds or subtracts an 8-bit step to a signed fixed-point phase word that has eight fraction bits, so one step unit is 1/256 of a clock cycle. The whole-cycle part of the word leaves the block as a signed cycle offset, which the waveform generator adds directly to its delay.

The fraction bits feed a first-order sigma-delta accumulator. That accumulator advances once per waveform period, on a strobe from the generator. Its carry bit asks for one extra cycle of delay in that period, so over many periods the average delay matches the fraction.

A fast-scan push button, active high, multiplies the step by eight while it is held, for coarse sweeps. The phase word saturates at its limits and never wraps, so a full-speed sweep stops cleanly at either end. The encoder phases and the button are brought into the clock domain inside the block.

Top module: `enc_phase_accum`

## Requirements
- R1: After reset the phase word, the sigma-delta state and the carry are all zero, so `intOffset` reads 0 and `carryOut` reads 0.
- R2: `encA`, `encB` and `fastBtn` each pass through a two-flop synchroniser. With {A,B} stepping through the sequence 00, 10, 11, 01, 00 (A leading), every single-bit change is one click that adds the step to the phase word. The new value is visible on `intOffset` three clock edges after the input change.
- R3: Stepping the other way (00, 01, 11, 10, 00) subtracts the step on every single-bit change.
- R4: A change in which A and B flip together is not a click and leaves the phase word unchanged.
- R5: The step is an unsigned count of 1/256-cycle units from 0 to 255. A step of 0 makes clicks change nothing.
- R6: While `fastBtn` is high at the moment of a click, that click moves the phase word by eight times the step. A click that arrives together with the release of the button uses the plain step.
- R7: The phase word saturates at +127*256+255 (integer part +127) and at -127*256 (integer part -127). It never wraps, including with the eightfold step.
- R8: `intOffset` is the integer part of the phase word, rounded toward minus infinity, as signed 8-bit two's complement. For example, -64/256 reads as -1.
- R9: On each clock edge with `periodStrobe` high, an 8-bit sigma-delta register adds the low 8 fraction bits of the phase word. `carryOut` takes the carry of that addition and holds it until the next strobe.
- R10: Without clicks the phase word does not change, whatever `periodStrobe` and `fastBtn` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| encA | input | 1 | Encoder phase A, asynchronous |
| encB | input | 1 | Encoder phase B, asynchronous |
| fastBtn | input | 1 | Fast-scan button, active high, asynchronous |
| stepSize | input | 8 | Step per click in 1/256-cycle units |
| periodStrobe | input | 1 | One-cycle pulse once per waveform period |
| intOffset | output | 8 | Signed integer cycle offset |
| carryOut | output | 1 | Sigma-delta extra-cycle bit for the current period |

## Verification
The hardest case to reach from the ports is saturation under the eightfold step. There the intermediate sum really goes past the phase-word range before the clamp. Reaching it takes more than a dozen full-step fast clicks in one direction, followed by a plain click on the same edge as the button release. The stimulus drives long runs of fast clicks with the step at 255 into each limit. It then reverses with the button released, which tells a clamped word apart from a wrapped one and a fast step apart from a plain one. Constrained-random clicks, double flips and strobes then wander across the range while a bench model tracks the fraction through the carry pattern.

// File: rtl/enc_phase_pkg.sv
package enc_phase_pkg;
  localparam int FAST_SHIFT = 3;

  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic fast;
  } clickCmd_t;
endpackage

// File: rtl/enc_phase_ctrl.sv
module enc_phase_ctrl
  import enc_phase_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      encA,
  input  logic      encB,
  input  logic      fastBtn,
  output clickCmd_t cmd
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] aPipe, bPipe, fPipe;
  logic [1:0] prevAb, curAb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aPipe  <= '0;
      bPipe  <= '0;
      fPipe  <= '0;
      prevAb <= 2'b00;
    end else begin
      aPipe  <= {aPipe[SYNC_STAGES-2:0], encA};
      bPipe  <= {bPipe[SYNC_STAGES-2:0], encB};
      fPipe  <= {fPipe[SYNC_STAGES-2:0], fastBtn};
      prevAb <= curAb;
    end
  end

  assign curAb = {aPipe[TOP], bPipe[TOP]};

  always_comb begin
    cmd = '0;
    cmd.fast = fPipe[TOP];
    case ({prevAb, curAb})
      4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: cmd.stepUp   = 1'b1;
      4'b00_01, 4'b01_11, 4'b11_10, 4'b10_00: cmd.stepDown = 1'b1;
      default: ;
    endcase
  end

  // R4: a double flip never produces a click
  p_double_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (curAb == ~prevAb) |-> (!cmd.stepUp && !cmd.stepDown));

  // R2: the previous state tracks the synchronised pair
  p_prev_tracks_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (prevAb == $past(curAb)));
endmodule

// File: rtl/enc_phase_dp.sv
module enc_phase_dp
  import enc_phase_pkg::*;
#(
  parameter int STEP_W = 8,
  parameter int FRAC_W = 8,
  parameter int INT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  clickCmd_t                cmd,
  input  logic [STEP_W-1:0]        stepSize,
  output logic signed [INT_W-1:0]  intOffset,
  output logic [FRAC_W-1:0]        frac
);
  localparam int ACC_W = INT_W + FRAC_W;
  localparam int EFF_W = STEP_W + FAST_SHIFT;
  localparam int SUM_W = ((ACC_W > EFF_W) ? ACC_W : EFF_W) + 2;
  localparam int ACC_MAX_I = (2 ** (ACC_W - 1)) - 1;
  localparam int ACC_MIN_I = (2 ** FRAC_W) - (2 ** (ACC_W - 1));
  localparam logic signed [SUM_W-1:0] ACC_MAX = SUM_W'(ACC_MAX_I);
  localparam logic signed [SUM_W-1:0] ACC_MIN = SUM_W'(ACC_MIN_I);

  logic signed [ACC_W-1:0] acc;
  logic signed [SUM_W-1:0] accExt, stepExt, rawSum, nextAcc;
  logic [EFF_W-1:0] effStep;

  always_comb begin
    effStep = cmd.fast ? {stepSize, {FAST_SHIFT{1'b0}}}
                       : {{FAST_SHIFT{1'b0}}, stepSize};
    accExt  = {{(SUM_W-ACC_W){acc[ACC_W-1]}}, acc};
    stepExt = {{(SUM_W-EFF_W){1'b0}}, effStep};
    if (cmd.stepUp)        rawSum = accExt + stepExt;
    else if (cmd.stepDown) rawSum = accExt - stepExt;
    else                   rawSum = accExt;
    if (rawSum > ACC_MAX)      nextAcc = ACC_MAX;
    else if (rawSum < ACC_MIN) nextAcc = ACC_MIN;
    else                       nextAcc = rawSum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acc <= '0;
    else       acc <= nextAcc[ACC_W-1:0];
  end

  assign intOffset = acc[ACC_W-1:FRAC_W];
  assign frac      = acc[FRAC_W-1:0];

  // R7: the phase word stays inside its limits
  p_acc_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    (accExt <= ACC_MAX) && (accExt >= ACC_MIN));

  // R7: saturation holds at the top
  p_top_sat_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepUp && accExt == ACC_MAX) |=> (accExt == ACC_MAX));

  // R7: saturation holds at the bottom
  p_bottom_sat_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepDown && accExt == ACC_MIN) |=> (accExt == ACC_MIN));

  // R10: no click, no change
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.stepUp && !cmd.stepDown) |=> $stable(acc));

  // R5: a plain click away from the limit adds exactly the step
  p_plain_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepUp && !cmd.fast && (accExt + SUM_W'(stepSize) <= ACC_MAX))
      |=> (accExt == $past(accExt) + SUM_W'($past(stepSize))));

  // R6: a fast click away from the limit subtracts eight steps
  p_fast_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepDown && cmd.fast && (accExt - (SUM_W'(stepSize) <<< FAST_SHIFT) >= ACC_MIN))
      |=> (accExt == $past(accExt) - (SUM_W'($past(stepSize)) <<< FAST_SHIFT)));
endmodule

// File: rtl/enc_phase_sd.sv
module enc_phase_sd #(
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FRAC_W-1:0] frac,
  input  logic              periodStrobe,
  output logic              carryOut
);
  logic [FRAC_W-1:0] sdAcc;
  logic [FRAC_W:0]   sdSum;

  assign sdSum = {1'b0, sdAcc} + {1'b0, frac};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdAcc    <= '0;
      carryOut <= 1'b0;
    end else if (periodStrobe) begin
      sdAcc    <= sdSum[FRAC_W-1:0];
      carryOut <= sdSum[FRAC_W];
    end
  end

  // R9: the carry only moves on a strobe
  p_carry_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !periodStrobe |=> $stable(carryOut));

  // R9: a strobe adds the fraction, carry included
  p_sd_update_r9: assert property (@(posedge clk) disable iff (!rstN)
    periodStrobe |=> ({carryOut, sdAcc} == ({1'b0, $past(sdAcc)} + {1'b0, $past(frac)})));
endmodule

// File: rtl/enc_phase_accum.sv
module enc_phase_accum
  import enc_phase_pkg::*;
#(
  parameter int STEP_W      = 8,
  parameter int FRAC_W      = 8,
  parameter int INT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    encA,
  input  logic                    encB,
  input  logic                    fastBtn,
  input  logic [STEP_W-1:0]       stepSize,
  input  logic                    periodStrobe,
  output logic signed [INT_W-1:0] intOffset,
  output logic                    carryOut
);
  clickCmd_t         cmd;
  logic [FRAC_W-1:0] frac;

  enc_phase_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB),
    .fastBtn(fastBtn), .cmd(cmd)
  );

  enc_phase_dp #(.STEP_W(STEP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .stepSize(stepSize),
    .intOffset(intOffset), .frac(frac)
  );

  enc_phase_sd #(.FRAC_W(FRAC_W)) u_sd (
    .clk(clk), .rstN(rstN), .frac(frac),
    .periodStrobe(periodStrobe), .carryOut(carryOut)
  );
endmodule

// File: tb/enc_phase_accum_test.sv
module enc_phase_accum_test;
  localparam int ACC_MAX = 127 * 256 + 255;
  localparam int ACC_MIN = -127 * 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic encA = 1'b0, encB = 1'b0, fastBtn = 1'b0, periodStrobe = 1'b0;
  logic [7:0] stepSize = 8'd0;
  logic signed [7:0] intOffset;
  logic carryOut;

  int checks = 0, failures = 0;
  int accM = 0, sdM = 0, carryM = 0, idx = 0;
  bit done = 0;

  always #5 clk = ~clk;

  enc_phase_accum uut (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB), .fastBtn(fastBtn),
    .stepSize(stepSize), .periodStrobe(periodStrobe),
    .intOffset(intOffset), .carryOut(carryOut)
  );

  function automatic logic [1:0] grayAt(int i);
    case (i & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  function automatic int clampAcc(int v);
    if (v > ACC_MAX) return ACC_MAX;
    if (v < ACC_MIN) return ACC_MIN;
    return v;
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // delta: 1 forward, 3 backward, 2 double flip
  task automatic move(int delta, bit fast, string req);
    int eff;
    @(negedge clk);
    idx = (idx + delta) & 3;
    {encA, encB} = grayAt(idx);
    fastBtn = fast;
    repeat (4) @(posedge clk);
    @(negedge clk);
    eff = fast ? int'(stepSize) * 8 : int'(stepSize);
    if (delta == 1) accM = clampAcc(accM + eff);
    else if (delta == 3) accM = clampAcc(accM - eff);
    check(req, int'(intOffset), accM >>> 8);
  endtask

  task automatic strobe(string req);
    int s;
    @(negedge clk);
    periodStrobe = 1'b1;
    @(negedge clk);
    periodStrobe = 1'b0;
    s = sdM + (accM & 255);
    carryM = s >> 8;
    sdM = s & 255;
    check(req, int'(carryOut), carryM);
    repeat (3) @(negedge clk);
    check({req, " hold"}, int'(carryOut), carryM);
    check("R10", int'(intOffset), accM >>> 8);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(intOffset), 0);
    check("R1", int'(carryOut), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    strobe("R1");

    // R2: forward clicks with a quarter-cycle step
    stepSize = 8'd64;
    for (int i = 0; i < 5; i++) move(1, 1'b0, "R2");
    // R9: fraction 64 gives carries 0,0,0,1
    for (int i = 0; i < 4; i++) strobe("R9");
    // R3 and R8: backward into negative values, floor rounding
    for (int i = 0; i < 6; i++) move(3, 1'b0, "R3");
    check("R8", int'(intOffset), -1);
    // R4: double flips ignored
    move(2, 1'b0, "R4");
    move(2, 1'b1, "R4");
    move(1, 1'b0, "R2");
    // R5: zero step
    stepSize = 8'd0;
    move(1, 1'b0, "R5");
    move(3, 1'b1, "R5");
    // R7/R6: fast run into the top limit
    stepSize = 8'd255;
    for (int i = 0; i < 22; i++) move(1, 1'b1, "R7");
    check("R7", int'(intOffset), 127);
    move(3, 1'b0, "R6");
    check("R6", int'(intOffset), 127);
    move(1, 1'b1, "R7");
    // fast run into the bottom limit
    for (int i = 0; i < 40; i++) move(3, 1'b1, "R7");
    check("R7", int'(intOffset), -127);
    move(1, 1'b0, "R6");
    strobe("R9");
    strobe("R10");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      bit f;
      op = int'($urandom % 8);
      f = ($urandom % 4) == 0;
      if (($urandom % 8) == 0) stepSize = 8'($urandom);
      if (op < 3) move(1, f, "R2");
      else if (op < 6) move(3, f, "R3");
      else if (op == 6) move(2, f, "R4");
      else strobe("R9");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule